// File: doc/BRIEF.md
# Wrapping Page Program Staging Buffer

This block sits behind the command decoder of a quad-wide serial flash front end. Once a page-program command and its three-byte start address have been decoded, the decoder pulses a start strobe. The block then takes the data nibbles that follow, high nibble first, and packs them into bytes. It stores each byte in a one-page staging buffer, indexed by a write offset. That offset begins at the low address byte and wraps inside the page. Any half byte still pending when chip select is released is thrown away.

When chip select rises, the block walks the whole page once, one offset per clock, starting at the start offset. For every offset that received data in this command it issues a write to the array. The written value is the current array contents ANDed with the staged byte, so programming can only clear bits. A command that delivered no complete byte produces no writes and no completion pulse. Array write circuitry and protection checks live elsewhere.

Top module: `pgb_wrap`

## Requirements
- R1: A start pulse (`cmd_go` with `sel_n` low while the block is idle) clears every per-offset flag, loads the write offset from `cmd_addr[7:0]` and the page base from `cmd_addr[23:8]`; data from an earlier command is never written again.
- R2: Nibbles on `nib_dat` with `nib_vld` pair up into bytes, the first nibble of each pair being bits 7:4 and the second bits 3:0.
- R3: The write offset advances by one per completed byte and goes from 0xFF to 0x00 within the same page; the page base never changes during a command.
- R4: When more than 256 bytes arrive, each offset holds the byte most recently written to it, so the last 256 bytes received are the ones committed.
- R5: A lone nibble left at the rising edge of `sel_n` is discarded and writes nothing.
- R6: After `sel_n` rises, the block scans 256 offsets, one per clock, in the order start offset, start+1, ... modulo 256. It raises `wr_vld` with `wr_addr` = {page base, offset} exactly for the offsets that received a byte in this command.
- R7: Each write carries `wr_data` = `arr_rdata` AND the staged byte, where `arr_rdata` is the current array contents at `wr_addr`.
- R8: If no complete byte was received, the rising edge of `sel_n` produces no `wr_vld`, no `commit_busy` and no `commit_done`.
- R9: `commit_busy` stays high for exactly 256 clocks of the scan, and `commit_done` pulses for one clock right after the scan ends.
- R10: Start pulses and nibbles are ignored while the scan runs, and nibbles are ignored outside a command.
- R11: After reset, `wr_vld`, `commit_busy` and `commit_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low; its rising edge ends a command |
| cmd_go | input | 1 | Page-program command and address decoded |
| cmd_addr | input | 24 | Start byte address of the command |
| nib_vld | input | 1 | Data nibble present |
| nib_dat | input | 4 | Data nibble |
| arr_rdata | input | 8 | Current array contents at `wr_addr` |
| wr_vld | output | 1 | Array write strobe for one byte |
| wr_addr | output | 24 | Byte address of the write |
| wr_data | output | 8 | Value to write |
| commit_busy | output | 1 | Page scan in progress |
| commit_done | output | 1 | One-clock pulse after the scan |

## Verification
A fresh command can arrive while the scan of the previous one is still running. The scan and the start of a new session then compete for the same cycles and the same flag storage. The bench provokes this by dropping chip select during a scan, pulsing the start strobe with a different address and sending a few nibbles. It then judges that the scoreboard receives exactly the writes of the first command, in scan order, and that no second scan or completion pulse follows. Page wrap and overflow are judged the same way, with the scoreboard expecting addresses that stay inside the start page.

// File: rtl/pgb_pkg.sv
package pgb_pkg;

  typedef enum logic [1:0] {
    PGB_IDLE  = 2'd0,
    PGB_FILL  = 2'd1,
    PGB_DRAIN = 2'd2
  } pgb_state_e;

  // programming can only clear bits
  function automatic logic [7:0] prog_merge(input logic [7:0] old_val,
                                            input logic [7:0] new_val);
    return old_val & new_val;
  endfunction

  // join high and low nibbles into a byte
  function automatic logic [7:0] nib_join(input logic [3:0] hi,
                                          input logic [3:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/pgb_nib_pack.sv
module pgb_nib_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       nib_vld,
  input  logic [3:0] nib_dat,
  output logic       byte_stb,
  output logic [7:0] byte_dat,
  output logic       half_pend
);
  import pgb_pkg::*;

  logic       phase_q;
  logic [3:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      hi_q    <= '0;
    end else if (clr) begin
      phase_q <= 1'b0;
    end else if (nib_vld) begin
      if (!phase_q) begin
        hi_q    <= nib_dat;
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
      end
    end
  end

  assign byte_stb  = nib_vld && phase_q && !clr;
  assign byte_dat  = nib_join(hi_q, nib_dat);
  assign half_pend = phase_q;

endmodule

// File: rtl/pgb_store.sv
module pgb_store #(
  parameter int PAGE_BYTES = 256,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_byte,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_byte,
  output logic             rd_flag,
  output logic             flag_any,
  output logic [OFF_W:0]   flag_cnt
);

  logic [7:0]            mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] flags_q;
  logic [OFF_W:0]        cnt_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_off] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      cnt_q   <= '0;
    end else if (clr_all) begin
      flags_q <= '0;
      cnt_q   <= '0;
    end else if (wr_en) begin
      flags_q[wr_off] <= 1'b1;
      if (!flags_q[wr_off]) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rd_byte  = mem[rd_off];
  assign rd_flag  = flags_q[rd_off];
  assign flag_cnt = cnt_q;
  assign flag_any = (cnt_q != '0);

endmodule

// File: rtl/pgb_ctrl.sv
module pgb_ctrl #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int BASE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              cmd_go,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_stb,
  input  logic              flag_any,
  output logic              sess_start,
  output logic              fill_end,
  output logic              drain_start,
  output logic              nib_en,
  output logic [OFF_W-1:0]  fill_off,
  output logic [OFF_W-1:0]  scan_off,
  output logic [BASE_W-1:0] page_base,
  output logic              busy,
  output logic              done
);
  import pgb_pkg::*;

  pgb_state_e        state_q;
  logic [OFF_W-1:0]  fill_off_q;
  logic [OFF_W-1:0]  start_off_q;
  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  scan_k_q;
  logic              done_q;
  logic              scan_last;

  always_comb begin
    sess_start  = (state_q == PGB_IDLE) && cmd_go && !sel_n;
    fill_end    = (state_q == PGB_FILL) && sel_n;
    drain_start = fill_end && flag_any;
    nib_en      = (state_q == PGB_FILL) && !sel_n;
    scan_last   = (scan_k_q == OFF_W'(PAGE_BYTES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PGB_IDLE;
      fill_off_q  <= '0;
      start_off_q <= '0;
      base_q      <= '0;
      scan_k_q    <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        PGB_IDLE: begin
          if (sess_start) begin
            state_q     <= PGB_FILL;
            fill_off_q  <= cmd_addr[OFF_W-1:0];
            start_off_q <= cmd_addr[OFF_W-1:0];
            base_q      <= cmd_addr[ADDR_W-1:OFF_W];
          end
        end
        PGB_FILL: begin
          if (fill_end) begin
            scan_k_q <= '0;
            state_q  <= drain_start ? PGB_DRAIN : PGB_IDLE;
          end else if (byte_stb) begin
            fill_off_q <= fill_off_q + 1'b1;
          end
        end
        PGB_DRAIN: begin
          scan_k_q <= scan_k_q + 1'b1;
          if (scan_last) begin
            state_q <= PGB_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= PGB_IDLE;
      endcase
    end
  end

  assign fill_off  = fill_off_q;
  assign scan_off  = start_off_q + scan_k_q;
  assign page_base = base_q;
  assign busy      = (state_q == PGB_DRAIN);
  assign done      = done_q;

endmodule

// File: rtl/pgb_wrap.sv
module pgb_wrap #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              cmd_go,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              nib_vld,
  input  logic [3:0]        nib_dat,
  input  logic [7:0]        arr_rdata,
  output logic              wr_vld,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              commit_busy,
  output logic              commit_done
);
  import pgb_pkg::*;

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - OFF_W;

  // named internal events, visible to the checker
  logic              ev_start;
  logic              ev_fill_end;
  logic              ev_drain;
  logic              nib_en;
  logic              byte_stb;
  logic [7:0]        byte_dat;
  logic              half_pend;
  logic [OFF_W-1:0]  fill_off;
  logic [OFF_W-1:0]  scan_off;
  logic [BASE_W-1:0] page_base;
  logic [7:0]        stage_byte;
  logic              stage_flag;
  logic              flag_any;
  logic [OFF_W:0]    flag_cnt;

  pgb_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cmd_go(cmd_go),
    .cmd_addr(cmd_addr), .byte_stb(byte_stb), .flag_any(flag_any),
    .sess_start(ev_start), .fill_end(ev_fill_end), .drain_start(ev_drain),
    .nib_en(nib_en), .fill_off(fill_off), .scan_off(scan_off),
    .page_base(page_base), .busy(commit_busy), .done(commit_done)
  );

  pgb_nib_pack u_pack (
    .clk(clk), .rst_n(rst_n), .clr(ev_start | ev_fill_end),
    .nib_vld(nib_vld && nib_en), .nib_dat(nib_dat),
    .byte_stb(byte_stb), .byte_dat(byte_dat), .half_pend(half_pend)
  );

  pgb_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_all(ev_start),
    .wr_en(byte_stb), .wr_off(fill_off), .wr_byte(byte_dat),
    .rd_off(scan_off), .rd_byte(stage_byte), .rd_flag(stage_flag),
    .flag_any(flag_any), .flag_cnt(flag_cnt)
  );

  assign wr_vld  = commit_busy && stage_flag;
  assign wr_addr = {page_base, scan_off};
  assign wr_data = prog_merge(arr_rdata, stage_byte);

endmodule

// File: rtl/pgb_wrap_chk.sv
module pgb_wrap_chk #(
  parameter int PAGE_BYTES = 256,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_vld,
  input logic [7:0]       wr_data,
  input logic [7:0]       arr_rdata,
  input logic             commit_busy,
  input logic             commit_done,
  input logic             ev_start,
  input logic             byte_stb,
  input logic [OFF_W-1:0] fill_off,
  input logic [OFF_W:0]   flag_cnt
);

  // R9
  done_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |-> (!commit_busy && $past(commit_busy)));

  // R6
  write_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |-> commit_busy);

  // R7
  clear_bits_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |-> ((wr_data & ~arr_rdata) == 8'h00));

  // R1
  flags_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (flag_cnt == '0));

  // R8
  scan_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_busy) |-> (flag_cnt != '0));

  // R3
  offset_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && (fill_off == OFF_W'(PAGE_BYTES - 1))) |=> (fill_off == '0));

  // R10
  no_fill_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_busy |-> !byte_stb);

endmodule

bind pgb_wrap pgb_wrap_chk #(.PAGE_BYTES(PAGE_BYTES)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_data(wr_data),
  .arr_rdata(arr_rdata), .commit_busy(commit_busy), .commit_done(commit_done),
  .ev_start(ev_start), .byte_stb(byte_stb), .fill_off(fill_off),
  .flag_cnt(flag_cnt)
);

// File: tb/test_pgb_wrap.sv
module test_pgb_wrap;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_n;
  logic        cmd_go;
  logic [23:0] cmd_addr;
  logic        nib_vld;
  logic [3:0]  nib_dat;
  logic [7:0]  arr_rdata;
  logic        wr_vld;
  logic [23:0] wr_addr;
  logic [7:0]  wr_data;
  logic        commit_busy;
  logic        commit_done;

  always #4 clk = ~clk;  // 125 MHz

  pgb_wrap i_pgb_wrap (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cmd_go(cmd_go),
    .cmd_addr(cmd_addr), .nib_vld(nib_vld), .nib_dat(nib_dat),
    .arr_rdata(arr_rdata), .wr_vld(wr_vld), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_busy(commit_busy), .commit_done(commit_done)
  );

  // array contents seen by the block: erased, or a fixed pattern
  bit arr_mode = 1'b0;
  assign arr_rdata = arr_mode ? ((wr_addr[7:0] ^ 8'h3C) | 8'h81) : 8'hFF;

  typedef struct {
    logic [23:0] a;
    logic [7:0]  d;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    done_seen = 0;
  int    busy_cyc = 0;
  int    cyc = 0;
  bit    fin = 1'b0;

  // reference model
  logic [7:0]  mb [256];
  bit          mf [256];
  logic [7:0]  m_ptr, m_start;
  logic [15:0] m_base;
  bit          m_half, m_active;
  logic [3:0]  m_hi;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (commit_done) done_seen++;
      if (commit_busy) busy_cyc++;
      if (wr_vld) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected write addr", int'(wr_addr), 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(wr_addr == it.a, it.tag, "write address", int'(wr_addr), int'(it.a));
          chk(wr_data == it.d, it.tag, "write data", int'(wr_data), int'(it.d));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic start_cmd(input logic [23:0] a);
    sel_n = 1'b0; cmd_go = 1'b1; cmd_addr = a;
    tick();
    cmd_go = 1'b0;
    for (int i = 0; i < 256; i++) mf[i] = 1'b0;
    m_ptr = a[7:0]; m_start = a[7:0]; m_base = a[23:8];
    m_half = 1'b0; m_active = 1'b1;
  endtask

  task automatic send_nib(input logic [3:0] n);
    nib_vld = 1'b1; nib_dat = n;
    tick();
    nib_vld = 1'b0;
    if (m_active) begin
      if (!m_half) begin
        m_hi = n; m_half = 1'b1;
      end else begin
        mb[m_ptr] = {m_hi, n}; mf[m_ptr] = 1'b1;
        m_ptr = m_ptr + 8'd1; m_half = 1'b0;
      end
    end
  endtask

  task automatic send_bytes(input int cnt, input int seed);
    for (int i = 0; i < cnt; i++) begin
      logic [7:0] b;
      b = 8'((seed + i * 37) ^ (i >> 3));
      send_nib(b[7:4]);
      send_nib(b[3:0]);
    end
  endtask

  task automatic finish_cmd(input string tag, input bit intrude);
    int n_exp;
    n_exp = 0;
    if (m_active) begin
      for (int k = 0; k < 256; k++) begin
        logic [7:0]  off;
        logic [23:0] ad;
        logic [7:0]  old;
        item_t it;
        off = m_start + 8'(k);
        if (mf[off]) begin
          ad = {m_base, off};
          old = arr_mode ? ((ad[7:0] ^ 8'h3C) | 8'h81) : 8'hFF;
          it.a = ad; it.d = old & mb[off]; it.tag = tag;
          exp_q.push_back(it);
          n_exp++;
        end
      end
    end
    m_active = 1'b0;
    done_seen = 0; busy_cyc = 0;
    sel_n = 1'b1;
    tick();
    if (n_exp > 0) begin
      if (intrude) begin
        // R10: new command and data during the scan are ignored
        repeat (10) tick();
        sel_n = 1'b0; cmd_go = 1'b1; cmd_addr = 24'h00F0F0;
        tick();
        cmd_go = 1'b0;
        for (int j = 0; j < 4; j++) send_nib(4'(j + 1));
        sel_n = 1'b1;
      end
      for (int w = 0; w < 600 && done_seen == 0; w++) tick();
      repeat (3) tick();
      chk(done_seen == 1, "R9", "done pulses", done_seen, 1);
      chk(busy_cyc == 256, "R9", "busy cycles", busy_cyc, 256);
      chk(exp_q.size() == 0, tag, "missing writes", exp_q.size(), 0);
      if (intrude) begin
        repeat (300) tick();
        chk(done_seen == 1, "R10", "extra commit after ignored command", done_seen, 1);
      end
    end else begin
      repeat (300) tick();
      chk(done_seen == 0, "R8", "done pulses", done_seen, 0);
      chk(busy_cyc == 0, "R8", "busy cycles", busy_cyc, 0);
    end
    exp_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; cmd_go = 1'b0; cmd_addr = '0;
    nib_vld = 1'b0; nib_dat = '0; m_active = 1'b0;
    repeat (5) tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    chk(wr_vld == 1'b0, "R11", "wr_vld", wr_vld, 0);
    chk(commit_busy == 1'b0, "R11", "commit_busy", commit_busy, 0);
    chk(commit_done == 1'b0, "R11", "commit_done", commit_done, 0);

    // R2 R6: plain program, mid page
    start_cmd(24'h012310); send_bytes(4, 8'h5A); finish_cmd("R2", 1'b0);

    // R3: wrap inside the page
    start_cmd(24'h0456FE); send_bytes(5, 8'h11); finish_cmd("R3", 1'b0);

    // R4: more than one page of data
    start_cmd(24'h078980); send_bytes(300, 8'h07); finish_cmd("R4", 1'b0);

    // R5: odd nibble count, trailing nibble dropped
    start_cmd(24'h000040); send_bytes(3, 8'h99); send_nib(4'hA); finish_cmd("R5", 1'b0);

    // R8: only a lone nibble
    start_cmd(24'h000000); send_nib(4'h3); finish_cmd("R8", 1'b0);

    // R7: non-erased array contents
    arr_mode = 1'b1;
    start_cmd(24'h00AB20); send_bytes(16, 8'hE4); finish_cmd("R7", 1'b0);

    // R1: same page again, fewer bytes: old flags must be gone
    start_cmd(24'h00AB20); send_bytes(2, 8'h3F); finish_cmd("R1", 1'b0);
    arr_mode = 1'b0;

    // R10: nibbles outside any command
    sel_n = 1'b0;
    for (int j = 0; j < 6; j++) send_nib(4'(j));
    finish_cmd("R10", 1'b0);

    // R10: command attempted during a scan
    start_cmd(24'h001234); send_bytes(3, 8'hC1); finish_cmd("R6", 1'b1);

    fin = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule